// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved outcomes. That register acts as an index into a table of 2-bit saturating counters. The upper bit of the selected counter is the guess. Because the counter is picked by the recent outcome pattern rather than by the branch address, the block learns any repeating outcome sequence whose period is five or shorter.

A fetch stage raises a request and receives a registered response one cycle later. The response carries the guess and the history value that produced it. When the branch resolves, the execute stage returns that history value together with the real outcome on the update port. The counter at the returned index moves one step towards the outcome. The outcome then enters the history register at its least significant bit, and the oldest outcome drops off the top.

Top module: `brp_two_level`

## Requirements
- R1: After reset the history register is zero and every counter holds 01 (weakly not taken). A request made straight after reset answers not taken with history 0000, and pred_valid_o is low until the first request.
- R2: When pred_req_i is high at a clock edge, pred_valid_o is high for exactly the next cycle. In that cycle pred_taken_o equals the upper bit of the counter that the history selected at that edge, and pred_hist_o equals that history. If pred_req_i is low, pred_valid_o is low in the next cycle.
- R3: An update with upd_taken_i=1 adds one to the counter at index upd_hist_i. A counter at 11 stays at 11.
- R4: An update with upd_taken_i=0 subtracts one from the counter at index upd_hist_i. A counter at 00 stays at 00.
- R5: Each update shifts upd_taken_i into bit 0 of the history, and bit 3 is discarded. Without an update, the history holds its value.
- R6: A counter in a strong state (11 or 00) needs two opposite outcomes in a row before its prediction changes.
- R7: A request and an update at the same edge give a response based on the state before that update.
- R8: Once trained by predict-then-update on its own history, the block predicts every outcome of a repeating pattern with a period of five or less without error.
- R9: pred_taken_o and pred_hist_o keep their values in cycles that follow an edge with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Prediction request |
| pred_valid_o | output | 1 | Response valid, one cycle after the request |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | 4 | History that indexed the prediction |
| upd_valid_i | input | 1 | Resolved branch update |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_hist_i | input | 4 | Counter index to train (history returned with the prediction) |

## Verification
The hardest cases to reach are a specific counter in a saturated state, read back through a prediction. The ports cannot read a counter directly. A counter is only visible when the global history happens to equal its index. The stimulus first trains one chosen index several times through upd_hist_i. It then writes four chosen outcomes, trained into a spare index, to steer the history onto that index. Only then does it request a prediction. This separates saturation from wrap-around, and hysteresis from a single-step flip. Pattern learning is then exercised with closed-loop training at periods three and five.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int unsigned HIST_W_DEF = 4;
  localparam int unsigned CNT_W_DEF  = 2;
  localparam int unsigned CNT_RST_DEF = 1;  // weakly not taken

  typedef enum logic [1:0] {
    CNT_SNT = 2'b00,
    CNT_WNT = 2'b01,
    CNT_WT  = 2'b10,
    CNT_ST  = 2'b11
  } cnt2_e;
endpackage

// File: rtl/brp_sat_ctr.sv
module brp_sat_ctr #(
  parameter int unsigned W       = 2,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         up_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = '1;
  localparam logic [W-1:0] MIN_V = '0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL[W-1:0];
    end else if (en_i) begin
      if (up_i && cnt_q != MAX_V)       cnt_q <= cnt_q + 1'b1;
      else if (!up_i && cnt_q != MIN_V) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/brp_ghr.sv
module brp_ghr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] hist_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/brp_pht.sv
module brp_pht #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int unsigned N = 1 << IDX_W;

  logic [CNT_W-1:0] cnt_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    brp_sat_ctr #(.W(CNT_W), .RST_VAL(RST_VAL)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (sel),
      .up_i  (wr_up_i),
      .cnt_o (cnt_arr[g])
    );
  end

  assign rd_cnt_o = cnt_arr[rd_idx_i];
endmodule

// File: rtl/brp_two_level.sv
module brp_two_level #(
  parameter int unsigned HIST_W  = brp_pkg::HIST_W_DEF,
  parameter int unsigned CNT_W   = brp_pkg::CNT_W_DEF,
  parameter int unsigned CNT_RST = brp_pkg::CNT_RST_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_req_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  logic [HIST_W-1:0] hist_q;
  logic [CNT_W-1:0]  rd_cnt;

  brp_ghr #(.W(HIST_W)) u_ghr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .bit_i  (upd_taken_i),
    .hist_o (hist_q)
  );

  brp_pht #(.IDX_W(HIST_W), .CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_pht (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(hist_q),
    .rd_cnt_o(rd_cnt),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_hist_i),
    .wr_up_i (upd_taken_i)
  );

  // response register: state sampled before same-edge update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b0;
      pred_hist_o  <= '0;
    end else begin
      pred_valid_o <= pred_req_i;
      if (pred_req_i) begin
        pred_taken_o <= rd_cnt[CNT_W-1];
        pred_hist_o  <= hist_q;
      end
    end
  end
endmodule

// File: rtl/brp_two_level_chk.sv
module brp_two_level_chk #(
  parameter int unsigned HIST_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pred_req_i,
  input logic              pred_valid_o,
  input logic              pred_taken_o,
  input logic [HIST_W-1:0] pred_hist_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist_q
);
  AST_RESP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_req_i |=> !pred_valid_o); // R2
  AST_RESP_HIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_hist_o == $past(hist_q)); // R2
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken_i)}); // R5
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_q)); // R5
  AST_RESP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_req_i |=> $stable(pred_taken_o) && $stable(pred_hist_o)); // R9
endmodule

bind brp_two_level brp_two_level_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pred_req_i  (pred_req_i),
  .pred_valid_o(pred_valid_o),
  .pred_taken_o(pred_taken_o),
  .pred_hist_o (pred_hist_o),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .hist_q      (hist_q)
);

// File: tb/sim_brp_two_level.sv
`timescale 1ns/1ps
module sim_brp_two_level;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pred_req_i = 1'b0;
  logic       pred_valid_o;
  logic       pred_taken_o;
  logic [3:0] pred_hist_o;
  logic       upd_valid_i = 1'b0;
  logic       upd_taken_i = 1'b0;
  logic [3:0] upd_hist_i = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model
  int m_ctr[16];
  int m_hist = 0;
  bit m_valid = 0;
  bit m_taken = 0;
  int m_rhist = 0;

  always #2 clk_i = ~clk_i;

  brp_two_level u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pred_req_i(pred_req_i), .pred_valid_o(pred_valid_o),
    .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
    .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
    .upd_hist_i(upd_hist_i)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // one clock: drive, step the model, compare all outputs
  task automatic step(bit rq, bit uv, bit ut, int uh, string req);
    @(negedge clk_i);
    pred_req_i  = rq;
    upd_valid_i = uv;
    upd_taken_i = ut;
    upd_hist_i  = 4'(uh);
    @(posedge clk_i);
    m_valid = rq;
    if (rq) begin
      m_taken = (m_ctr[m_hist] >= 2);
      m_rhist = m_hist;
    end
    if (uv) begin
      if (ut && m_ctr[uh] < 3) m_ctr[uh]++;
      if (!ut && m_ctr[uh] > 0) m_ctr[uh]--;
      m_hist = ((m_hist << 1) | int'(ut)) & 15;
    end
    #1;
    chk({req, " valid"}, int'(pred_valid_o), int'(m_valid));
    chk({req, " taken"}, int'(pred_taken_o), int'(m_taken));
    chk({req, " hist"},  int'(pred_hist_o),  m_rhist);
  endtask

  // steer history to h[3:0] (oldest first), training spare index 0
  task automatic set_hist(int h);
    for (int i = 3; i >= 0; i--) step(0, 1, h[i], 0, "R5");
  endtask

  task automatic pattern(int pat, int len, int iters, string req);
    for (int i = 0; i < iters; i++) begin
      bit o;
      logic [3:0] h;
      o = pat[i % len];
      step(1, 0, 0, 0, req);
      h = pred_hist_o;
      if (i >= iters - 2 * len) chk({req, " trained guess"}, int'(pred_taken_o), int'(o));
      step(0, 1, o, int'(h), req);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog got=%0d exp=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_ctr[i] = 1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 valid at reset", int'(pred_valid_o), 0);
    chk("R1 taken at reset", int'(pred_taken_o), 0);
    chk("R1 hist at reset", int'(pred_hist_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    step(0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, "R1");
    chk("R1 first guess", int'(pred_taken_o), 0);
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");

    // R7: same-edge request and update at index 0
    step(1, 1, 1, 0, "R7");
    chk("R7 pre-update guess", int'(pred_taken_o), 0);
    chk("R7 pre-update hist", int'(pred_hist_o), 0);
    step(1, 0, 0, 0, "R7");
    chk("R7 next hist", int'(pred_hist_o), 1);

    // R5: outcomes 1,0,1,1,1 -> 0111
    step(0, 1, 1, 15, "R5");
    step(0, 1, 0, 15, "R5");
    step(0, 1, 1, 15, "R5");
    step(0, 1, 1, 15, "R5");
    step(0, 1, 1, 15, "R5");
    step(1, 0, 0, 0, "R5");
    chk("R5 shifted hist", int'(pred_hist_o), 7);

    // R3 + R6: index 9 taken x5 saturates at 11; one not-taken keeps taken
    for (int i = 0; i < 5; i++) step(0, 1, 1, 9, "R3");
    step(0, 1, 0, 9, "R6");
    set_hist(9);
    step(1, 0, 0, 0, "R3");
    chk("R3 saturate high then one miss", int'(pred_taken_o), 1);
    step(0, 1, 0, 9, "R6");
    set_hist(9);
    step(1, 0, 0, 0, "R6");
    chk("R6 second miss flips", int'(pred_taken_o), 0);

    // R4: index 6 not-taken x4 saturates at 00; one taken stays not taken
    for (int i = 0; i < 4; i++) step(0, 1, 0, 6, "R4");
    step(0, 1, 1, 6, "R4");
    set_hist(6);
    step(1, 0, 0, 0, "R4");
    chk("R4 saturate low then one hit", int'(pred_taken_o), 0);

    // R8: period-5 pattern T T N T N and period-3 pattern T T N
    pattern(5'b01011, 5, 40, "R8 p5");
    pattern(3'b011, 3, 30, "R8 p3");

    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule